// File: doc/BRIEF.md
# Lockable GPIO Bank Register File

This block is the register file of a general-purpose I/O controller. It holds up to eight banks of 32 pins. For every pin it keeps a direction bit and an output value, and it drives the pad outputs and output enables from them. Pad inputs pass through a two-stage synchronizer before software can read them. Software reaches the block over a plain synchronous bus with an address, a write strobe, write data and registered read data.

Each bank has separate write-one-to-set and write-one-to-clear words, so software can change single output bits without a read-modify-write. Pins can be write-protected one at a time. A per-bank protection word accepts a new value only when the bus write just before it put the fixed key 0x00A5A501 into the key register. While a pin is protected, writes to its direction bit, its set bit and its clear bit have no effect. Its state can still be read.

Interrupt detection, debounce and pad electrical behaviour belong to other blocks. Addresses in the interrupt range read as zero here.

Top module: `gpio_lockable_regs`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0, control bit 0 reads 1), every output is 0 (`pin_out` all 0), and every protection word reads 0.
- R2: The control word of pin p is at byte address 0x100 + 4*p, where p = bank*32 + bit. Bit 0 is the direction: 1 means input and 0 means output. `pin_oe[p]` is 1 exactly when the pin is an output, and a read returns the direction in bit 0 with zeros above it.
- R3: Writing the set word of bank b (0x040 + 4*b) drives high each pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R4: Writing the clear word of bank b (0x060 + 4*b) drives low each pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: The output-status word (0x000 + 4*b) reads the driven output values. The input-status word (0x020 + 4*b) reads `pin_in` through two flops, so a change on `pin_in` shows in read data that is captured at the third rising edge after the change.
- R6: A write to the protection word of bank b (0x500 + 4*b) takes effect only when the bus write just before it wrote 0x00A5A501 to the key register at 0x520. Otherwise the write is dropped.
- R7: Any bus write other than a correct key write disarms the key. This includes a key write with any other value and a write to a read-only word. Read cycles leave the key armed.
- R8: A pin whose protection bit is 1 ignores writes to its control word, its set bit and its clear bit. Unprotected pins addressed by the same word are still updated.
- R9: The protection words read back as written. All ones protects the whole bank and all zeros releases it. Reads are allowed whatever the protection state.
- R10: Read data is registered: `bus_rdata` shows the word addressed in the previous cycle. Unmapped or unaligned addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pin_in | input | NUM_BANKS*32 | Pad input values (asynchronous) |
| pin_out | output | NUM_BANKS*32 | Pad output values |
| pin_oe | output | NUM_BANKS*32 | Pad output enables, 1 = drive |

## Verification
Two functions can apply in the same cycle: the protection filter and a set or clear update both act on one bank word in one write. The bench protects the upper nibble of a bank whose outputs hold a known mixed pattern. It then writes all ones to that bank's clear word and expects the protected bits to keep their old value while every other bit goes to zero. Key disarming and protection-word acceptance also meet in one write: a correct key followed by a write to a read-only word and then a protection write must leave the protection word unchanged, and a read placed between the key and the protection write must not stop the protection write from landing.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam int PINS_PER_BANK = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h100;
  localparam logic [BUS_AW-1:0] OFS_KEY  = 12'h520;
  localparam logic [BUS_DW-1:0] KEY_WORD = 32'h00A5A501;

  // addr[11:5] selects the per-bank group; addr[4:2] selects the bank
  localparam logic [6:0] GRP_OUT  = 7'h00;
  localparam logic [6:0] GRP_IN   = 7'h01;
  localparam logic [6:0] GRP_SET  = 7'h02;
  localparam logic [6:0] GRP_CLR  = 7'h03;
  localparam logic [6:0] GRP_LOCK = 7'h28;

  typedef enum logic [2:0] {
    REG_NONE, REG_OUT, REG_IN, REG_SET, REG_CLR, REG_LOCK, REG_KEY, REG_CTRL
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;   // bank number, or pin number for REG_CTRL
  } reg_sel_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= async_in;
      hold_q <= meta_q;
    end
  end

  assign sync_out = hold_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic [BUS_AW-1:0] addr,
  output reg_sel_t          sel
);
  localparam int NUM_PINS = NUM_BANKS * PINS_PER_BANK;
  localparam int CTRL_SPAN = 4 * NUM_PINS;

  logic [BUS_AW-1:0] ctrl_off;
  logic [2:0]        bank_f;
  logic              bank_ok;

  assign ctrl_off = addr - OFS_CTRL;
  assign bank_f   = addr[4:2];
  assign bank_ok  = (int'(bank_f) < NUM_BANKS);

  always_comb begin
    sel.kind = REG_NONE;
    sel.idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == OFS_KEY) begin
        sel.kind = REG_KEY;
      end else if (addr >= OFS_CTRL && int'(ctrl_off) < CTRL_SPAN) begin
        sel.kind = REG_CTRL;
        sel.idx  = ctrl_off[9:2];
      end else if (bank_ok) begin
        sel.idx = {5'b0, bank_f};
        case (addr[11:5])
          GRP_OUT:  sel.kind = REG_OUT;
          GRP_IN:   sel.kind = REG_IN;
          GRP_SET:  sel.kind = REG_SET;
          GRP_CLR:  sel.kind = REG_CLR;
          GRP_LOCK: sel.kind = REG_LOCK;
          default:  sel.kind = REG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_key_guard.sv
module gpio_key_guard
  import gpio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_key,
  input  logic [BUS_DW-1:0] wr_data,
  output logic              armed
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (wr_en) armed_d = wr_is_key && (wr_data == KEY_WORD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= armed_d;
  end

  assign armed = armed_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int PINS = PINS_PER_BANK
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ctrl,
  input  logic [$clog2(PINS)-1:0] ctrl_bit,
  input  logic                    ctrl_dir,
  input  logic                    wr_set,
  input  logic                    wr_clr,
  input  logic                    wr_lock,
  input  logic [PINS-1:0]         wr_data,
  output logic [PINS-1:0]         out_q,
  output logic [PINS-1:0]         dir_q,
  output logic [PINS-1:0]         lock_q
);
  logic [PINS-1:0] out_d;
  logic [PINS-1:0] dir_d;
  logic [PINS-1:0] lock_d;
  logic [PINS-1:0] open_bits;
  logic            out_en;
  logic            dir_en;

  assign open_bits = wr_data & ~lock_q;
  assign out_en    = wr_set | wr_clr;
  assign dir_en    = wr_ctrl & ~lock_q[ctrl_bit];

  always_comb begin
    out_d = out_q;
    if (wr_set) out_d = out_q | open_bits;
    else if (wr_clr) out_d = out_q & ~open_bits;
    dir_d = dir_q;
    dir_d[ctrl_bit] = ctrl_dir;
    lock_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      lock_q <= '0;
    end else begin
      if (out_en)  out_q  <= out_d;
      if (dir_en)  dir_q  <= dir_d;
      if (wr_lock) lock_q <= lock_d;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_guard
    // R8: a protected pin keeps its output and direction
    a_r8_locked_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> $stable(out_q[i]));
    a_r8_locked_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> $stable(dir_q[i]));
  end
endmodule

// File: rtl/gpio_lockable_regs.sv
module gpio_lockable_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [BUS_AW-1:0]                  bus_addr,
  input  logic                               bus_we,
  input  logic [BUS_DW-1:0]                  bus_wdata,
  output logic [BUS_DW-1:0]                  bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_oe
);
  localparam int NUM_PINS = NUM_BANKS * PINS_PER_BANK;
  localparam int PIN_W    = $clog2(NUM_PINS);
  localparam int BIT_W    = $clog2(PINS_PER_BANK);
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                     rst_n_s;
  reg_sel_t                 sel;
  logic                     key_armed;
  logic [NUM_PINS-1:0]      in_sync;
  logic [NUM_PINS-1:0]      out_flat;
  logic [NUM_PINS-1:0]      dir_flat;
  logic [NUM_PINS-1:0]      lock_flat;
  logic [PINS_PER_BANK-1:0] out_bank  [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] dir_bank  [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] lock_bank [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] in_bank   [NUM_BANKS];
  logic [BANK_W-1:0]        bank_sel;
  logic [BUS_DW-1:0]        rdata_d;
  logic [BUS_DW-1:0]        rdata_q;

  gpio_rst_sync i_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_key_guard i_key (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (bus_we),
    .wr_is_key (sel.kind == REG_KEY),
    .wr_data   (bus_wdata),
    .armed     (key_armed)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_in_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    logic hit_pin;
    assign hit_bank = (int'(sel.idx) == b);
    assign hit_pin  = (int'(sel.idx[PIN_W-1:BIT_W]) == b);

    gpio_bank_regs #(.PINS(PINS_PER_BANK)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_ctrl  (bus_we && sel.kind == REG_CTRL && hit_pin),
      .ctrl_bit (sel.idx[BIT_W-1:0]),
      .ctrl_dir (bus_wdata[0]),
      .wr_set   (bus_we && sel.kind == REG_SET && hit_bank),
      .wr_clr   (bus_we && sel.kind == REG_CLR && hit_bank),
      .wr_lock  (bus_we && sel.kind == REG_LOCK && hit_bank && key_armed),
      .wr_data  (bus_wdata),
      .out_q    (out_bank[b]),
      .dir_q    (dir_bank[b]),
      .lock_q   (lock_bank[b])
    );

    assign in_bank[b] = in_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
    assign out_flat[b*PINS_PER_BANK +: PINS_PER_BANK]  = out_bank[b];
    assign dir_flat[b*PINS_PER_BANK +: PINS_PER_BANK]  = dir_bank[b];
    assign lock_flat[b*PINS_PER_BANK +: PINS_PER_BANK] = lock_bank[b];
  end

  assign bank_sel = sel.idx[BANK_W-1:0];

  always_comb begin
    case (sel.kind)
      REG_OUT:  rdata_d = out_bank[bank_sel];
      REG_IN:   rdata_d = in_bank[bank_sel];
      REG_LOCK: rdata_d = lock_bank[bank_sel];
      REG_CTRL: rdata_d = {{(BUS_DW-1){1'b0}}, dir_flat[sel.idx[PIN_W-1:0]]};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_flat;
  assign pin_oe    = ~dir_flat;

  // R6: protection words change only while the key is armed
  a_r6_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n_s)
    !key_armed |=> $stable(lock_flat));

  // R7: any write that is not a key write leaves the key disarmed
  a_r7_write_disarms: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && sel.kind != REG_KEY) |=> !key_armed);

  // R7: read cycles do not disturb the armed key
  a_r7_read_keeps_key: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_we && key_armed) |=> key_armed);
endmodule

// File: tb/test_gpio_lockable_regs.sv
module test_gpio_lockable_regs;
  localparam int NB = 8;
  localparam int NP = NB * 32;

  logic          clk;
  logic          rst_n;
  logic [11:0]   bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  gpio_lockable_regs #(.NUM_BANKS(NB)) i_gpio_lockable_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h100, 32'h0,        32'h0,        4'd2},  // R2 pin0 output
    '{1'b1, 12'h104, 32'h0,        32'h0,        4'd2},  // R2 pin1 output
    '{1'b1, 12'h040, 32'h00000003, 32'h0,        4'd3},  // R3 set pins 0,1
    '{1'b0, 12'h000, 32'h0,        32'h00000003, 4'd3},  // R3
    '{1'b1, 12'h060, 32'h00000001, 32'h0,        4'd4},  // R4 clear pin0
    '{1'b0, 12'h000, 32'h0,        32'h00000002, 4'd4},  // R4
    '{1'b1, 12'h048, 32'hF0F00000, 32'h0,        4'd3},  // R3 bank2
    '{1'b0, 12'h008, 32'h0,        32'hF0F00000, 4'd3},  // R3
    '{1'b1, 12'h068, 32'h30000000, 32'h0,        4'd4},  // R4 bank2
    '{1'b0, 12'h008, 32'h0,        32'hC0F00000, 4'd4},  // R4
    '{1'b0, 12'h100, 32'h0,        32'h00000000, 4'd2},  // R2 output reads 0
    '{1'b0, 12'h108, 32'h0,        32'h00000001, 4'd2},  // R2 input reads 1
    '{1'b0, 12'h7FC, 32'h0,        32'h00000000, 4'd10}, // R10 unmapped
    '{1'b0, 12'h101, 32'h0,        32'h00000000, 4'd10}, // R10 unaligned
    '{1'b1, 12'h520, 32'h00A5A501, 32'h0,        4'd6},  // R6 key
    '{1'b1, 12'h500, 32'h00000001, 32'h0,        4'd6},  // R6 protect pin0
    '{1'b0, 12'h500, 32'h0,        32'h00000001, 4'd6},  // R6
    '{1'b1, 12'h040, 32'h00000001, 32'h0,        4'd8},  // R8 set protected
    '{1'b0, 12'h000, 32'h0,        32'h00000002, 4'd8},  // R8
    '{1'b1, 12'h100, 32'h00000001, 32'h0,        4'd8},  // R8 ctrl protected
    '{1'b0, 12'h100, 32'h0,        32'h00000000, 4'd8},  // R8
    '{1'b1, 12'h500, 32'h00000000, 32'h0,        4'd6},  // R6 no key
    '{1'b0, 12'h500, 32'h0,        32'h00000001, 4'd6},  // R6 dropped
    '{1'b1, 12'h520, 32'h00A5A501, 32'h0,        4'd7},  // R7 key
    '{1'b1, 12'h000, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7 write to read-only
    '{1'b1, 12'h500, 32'h00000000, 32'h0,        4'd7},  // R7 must drop
    '{1'b0, 12'h500, 32'h0,        32'h00000001, 4'd7},  // R7
    '{1'b1, 12'h520, 32'h00A5A501, 32'h0,        4'd7},  // R7 key
    '{1'b0, 12'h000, 32'h0,        32'h00000002, 4'd7},  // R7 read between
    '{1'b1, 12'h500, 32'h00000000, 32'h0,        4'd7},  // R7 accepted
    '{1'b0, 12'h500, 32'h0,        32'h00000000, 4'd7},  // R7
    '{1'b1, 12'h520, 32'h00A5A501, 32'h0,        4'd9},  // R9 key
    '{1'b1, 12'h504, 32'hFFFFFFFF, 32'h0,        4'd9},  // R9 protect bank1
    '{1'b0, 12'h504, 32'h0,        32'hFFFFFFFF, 4'd9},  // R9
    '{1'b1, 12'h180, 32'h00000000, 32'h0,        4'd8},  // R8 pin32 ctrl
    '{1'b0, 12'h180, 32'h0,        32'h00000001, 4'd8},  // R8 still input
    '{1'b1, 12'h520, 32'h00A5A500, 32'h0,        4'd7},  // R7 wrong key
    '{1'b1, 12'h500, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7 dropped
    '{1'b0, 12'h500, 32'h0,        32'h00000000, 4'd7},  // R7
    '{1'b1, 12'h520, 32'h00A5A501, 32'h0,        4'd8},  // R8 key
    '{1'b1, 12'h508, 32'hF0000000, 32'h0,        4'd8},  // R8 protect bank2 top
    '{1'b1, 12'h068, 32'hFFFFFFFF, 32'h0,        4'd8}   // R8 clear all bank2
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; bus_wdata = '0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(1, pin_oe[31:0], 32'h0);
    check(1, pin_out[31:0], 32'h0);
    check(1, {31'b0, |pin_oe}, 32'h0);
    check(1, {31'b0, |pin_out}, 32'h0);
    bus_read(12'h500, rd); check(1, rd, 32'h0);
    bus_read(12'h51C, rd); check(1, rd, 32'h0);
    bus_read(12'h100, rd); check(1, rd, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check(int'(VECS[i].req), rd, VECS[i].exp);
      end
    end

    // R8: the clear left protected bits 31:28 of bank2 and zeroed the rest
    bus_read(12'h008, rd); check(8, rd, 32'hC0000000);
    check(8, pin_out[95:64], 32'hC0000000);
    // R2 enables at the ports
    check(2, pin_oe[31:0], 32'h00000003);
    check(2, {31'b0, pin_oe[32]}, 32'h0);
    check(3, pin_out[31:0], 32'h00000002);

    // R5 input synchronizer latency, R10 registered read
    @(negedge clk);
    bus_addr = 12'h020; bus_we = 1'b0; pin_in[31:0] = 32'hDEADBEEF;
    @(negedge clk); check(5, bus_rdata, 32'h0);
    @(negedge clk); check(5, bus_rdata, 32'h0);
    @(negedge clk); check(5, bus_rdata, 32'hDEADBEEF);
    pin_in[255:224] = 32'h12345678;
    repeat (3) @(negedge clk);
    bus_read(12'h03C, rd); check(5, rd, 32'h12345678);
    // R10: rdata follows the address of the previous cycle
    @(negedge clk);
    bus_addr = 12'h000;
    @(negedge clk); check(10, bus_rdata, 32'h00000002);

    finished = 1;
    finish_run();
  end
endmodule